// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical page frame. The request gives the page number (linear address bits 31:12), a write flag, the current privilege level and a write-protect enable. A small fully associative translation cache is checked first. On a miss the block reads the page directory entry and then the page table entry over a simple 32-bit memory port, one transaction at a time. It writes back the status bits it has to set, merges the permissions of the two levels, and fills the cache.

Each request ends in a one-cycle response. The response carries either the frame with its merged writable and user permissions, or a page fault with a 3-bit code. The caller splits accesses that cross a page. A single flush input drops every cached translation.

Top module: `pt_walker`

## Requirements
- R1: The directory entry address is `{dir_base, page[19:10], 2'b00}`. The table entry address is `{pde[31:12], page[9:0], 2'b00}`.
- R2: If the entry read at either level has bit 0 (present) clear, the walk stops with no further memory access. The response is a fault with code 0, frame 0 and both permissions 0, and nothing is cached.
- R3: A directory entry read with bit 5 (accessed) clear is written back with bit 5 set before the table entry is read.
- R4: The table entry gets bit 5 set, and also bit 6 (dirty) when the request is a write. It is written back only if this changed its value.
- R5: The reported writable flag is table bit 1 AND directory bit 1. The reported user flag is table bit 2 AND directory bit 2. The frame is table bits 31:12.
- R6: A fault is raised when the user flag is 0 and the privilege level is not 0, or when the request is a write with write-protect set and the writable flag is 0. The fault code is `{user, writable, 1}`. Without a fault the code is 0.
- R7: A cache hit on the page number answers in the cycle after acceptance, with no memory access. The fault rule of R6 is applied to the new request's privilege, write flag and write-protect.
- R8: The cache holds 16 translations and replaces them round-robin. It is filled once per walk that finds both entries present, including walks that end in a permission fault.
- R9: A flush pulse invalidates every cached translation from the next cycle on.
- R10: The block accepts a request only when idle (`req_ready` high). It has at most one memory transaction open. Address, write flag and write data hold steady until `mem_ready`.
- R11: A walk's response appears in the cycle after the handshake of its last memory transaction. `rsp_valid` is high for one cycle per request.
- R12: After reset `req_ready` is 1, `mem_valid` is 0, `rsp_valid` is 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| dir_base | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_page | input | 20 | Linear address bits 31:12 |
| req_write | input | 1 | Request is a write |
| req_cpl | input | 2 | Current privilege level |
| req_wp | input | 1 | Write-protect enable |
| mem_valid | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Transaction accepted; read data valid this cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Page fault |
| rsp_code | output | 3 | Fault code |
| rsp_frame | output | 20 | Physical frame number |
| rsp_writable | output | 1 | Merged writable permission |
| rsp_user | output | 1 | Merged user permission |

## Verification
A cache hit's response is due one cycle after the accepting edge. A walk of n memory transactions answers n edges after acceptance when memory never stalls. The bench counts edges from acceptance to `rsp_valid` in its no-stall phase and compares the count with the number of transactions its model predicts. Every memory handshake is checked on the cycle it happens against the model's queue of expected reads and writes. A later phase stalls `mem_ready` from a pseudo-random sequence and checks only contents and order, not timing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFS_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned FRAME_W = ADDR_W - OFS_W;

  localparam int unsigned BIT_P = 0;
  localparam int unsigned BIT_W = 1;
  localparam int unsigned BIT_U = 2;
  localparam int unsigned BIT_A = 5;
  localparam int unsigned BIT_D = 6;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic               wr_ok;
    logic               usr_ok;
  } xlate_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WB
  } walk_state_e;

  // directory slot: root frame, upper page-number field, word aligned
  function automatic logic [ADDR_W-1:0] dir_entry_addr(
      input logic [FRAME_W-1:0] root, input logic [FRAME_W-1:0] vpn);
    return {root, vpn[FRAME_W-1:IDX_W], 2'b00};
  endfunction

  // table slot: frame held in the directory entry, lower page-number field
  function automatic logic [ADDR_W-1:0] tbl_entry_addr(
      input logic [ADDR_W-1:0] pde, input logic [FRAME_W-1:0] vpn);
    return {pde[ADDR_W-1:OFS_W], vpn[IDX_W-1:0], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] mark_status(
      input logic [ADDR_W-1:0] ent, input logic wr);
    logic [ADDR_W-1:0] r;
    r        = ent;
    r[BIT_A] = 1'b1;
    if (wr) r[BIT_D] = 1'b1;
    return r;
  endfunction

  function automatic xlate_t merge_levels(
      input logic [ADDR_W-1:0] pde, input logic [ADDR_W-1:0] pte);
    xlate_t x;
    x.frame  = pte[ADDR_W-1:OFS_W];
    x.wr_ok  = pte[BIT_W] & pde[BIT_W];
    x.usr_ok = pte[BIT_U] & pde[BIT_U];
    return x;
  endfunction

  function automatic logic access_fault(
      input xlate_t x, input logic wr, input logic [1:0] cpl, input logic wp);
    return (!x.usr_ok && (cpl != 2'd0)) || (wr && wp && !x.wr_ok);
  endfunction

  function automatic logic [2:0] fault_code(input xlate_t x, input logic flt);
    return flt ? {x.usr_ok, x.wr_ok, 1'b1} : 3'b000;
  endfunction

endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb
  import ptw_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [FRAME_W-1:0] lk_vpn,
  output logic               lk_hit,
  output xlate_t             lk_rec,
  input  logic               fill_en,
  input  logic [FRAME_W-1:0] fill_vpn,
  input  xlate_t             fill_rec
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int REC_W = $bits(xlate_t);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [FRAME_W-1:0] tag_q [ENTRIES];
  xlate_t             rec_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  assign lk_hit = |match;

  always_comb begin
    lk_rec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_rec = xlate_t'(lk_rec | (rec_q[i] & {REC_W{match[i]}}));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[rr_q] <= 1'b1;
      rr_q          <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[rr_q] <= fill_vpn;
      rec_q[rr_q] <= fill_rec;
    end
  end

  // R9: nothing can hit in the cycle after a flush
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  // R8: fills happen only on misses, so one page never sits in two slots
  p_unique_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/ptw_walk.sv
module ptw_walk
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FRAME_W-1:0] req_vpn,
  input  logic               req_write,
  input  logic [1:0]         req_cpl,
  input  logic               req_wp,
  input  logic [FRAME_W-1:0] dir_base,
  input  logic               lk_hit,
  input  xlate_t             lk_rec,
  output logic               fill_en,
  output logic [FRAME_W-1:0] fill_vpn,
  output xlate_t             fill_rec,
  output logic               hit_serve,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  input  logic [ADDR_W-1:0]  mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [2:0]         rsp_code,
  output xlate_t             rsp_rec
);

  localparam logic [ADDR_W-1:0] ACC_MASK = ADDR_W'(1) << BIT_A;

  walk_state_e        st_q;
  logic [FRAME_W-1:0] vpn_q, root_q;
  logic               wr_q, wp_q;
  logic [1:0]         cpl_q;
  logic [ADDR_W-1:0]  pde_q, pte_q, pte_raw_q;
  logic               rsp_valid_q, rsp_fault_q;
  logic [2:0]         rsp_code_q;
  xlate_t             rsp_rec_q;

  logic              accept, fire, entry_ok, tbl_rd_fire, tbl_clean;
  logic              walk_done, tbl_wb_fire;
  logic [ADDR_W-1:0] pte_marked;
  xlate_t            walk_rec;
  logic              hit_fault, fin_fault;

  assign req_ready   = (st_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign hit_serve   = accept && lk_hit;
  assign mem_valid   = (st_q != ST_IDLE);
  assign fire        = mem_valid && mem_ready;
  assign entry_ok    = mem_rdata[BIT_P];
  assign pte_marked  = mark_status(mem_rdata, wr_q);
  assign tbl_clean   = (pte_marked == mem_rdata);
  assign tbl_rd_fire = (st_q == ST_TBL_RD) && fire;
  assign tbl_wb_fire = (st_q == ST_TBL_WB) && fire;
  assign walk_done   = (tbl_rd_fire && entry_ok && tbl_clean) || tbl_wb_fire;
  assign walk_rec    = merge_levels(pde_q, (st_q == ST_TBL_WB) ? pte_q : mem_rdata);
  assign hit_fault   = access_fault(lk_rec, req_write, req_cpl, req_wp);
  assign fin_fault   = access_fault(walk_rec, wr_q, cpl_q, wp_q);

  assign fill_en  = walk_done;
  assign fill_vpn = vpn_q;
  assign fill_rec = walk_rec;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = dir_entry_addr(root_q, vpn_q);
    mem_wdata = '0;
    case (st_q)
      ST_DIR_WB: begin
        mem_we    = 1'b1;
        mem_wdata = pde_q;
      end
      ST_TBL_RD: mem_addr = tbl_entry_addr(pde_q, vpn_q);
      ST_TBL_WB: begin
        mem_addr  = tbl_entry_addr(pde_q, vpn_q);
        mem_we    = 1'b1;
        mem_wdata = pte_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      vpn_q       <= '0;
      root_q      <= '0;
      wr_q        <= 1'b0;
      wp_q        <= 1'b0;
      cpl_q       <= '0;
      pde_q       <= '0;
      pte_q       <= '0;
      pte_raw_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_code_q  <= '0;
      rsp_rec_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            vpn_q  <= req_vpn;
            root_q <= dir_base;
            wr_q   <= req_write;
            cpl_q  <= req_cpl;
            wp_q   <= req_wp;
            if (lk_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= hit_fault;
              rsp_code_q  <= fault_code(lk_rec, hit_fault);
              rsp_rec_q   <= lk_rec;
            end else begin
              st_q <= ST_DIR_RD;
            end
          end
        end
        ST_DIR_RD: begin
          if (fire) begin
            if (!entry_ok) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_code_q  <= '0;
              rsp_rec_q   <= '0;
              st_q        <= ST_IDLE;
            end else begin
              pde_q <= mem_rdata | ACC_MASK;
              st_q  <= mem_rdata[BIT_A] ? ST_TBL_RD : ST_DIR_WB;
            end
          end
        end
        ST_DIR_WB: begin
          if (fire) st_q <= ST_TBL_RD;
        end
        ST_TBL_RD: begin
          if (fire) begin
            if (!entry_ok) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_code_q  <= '0;
              rsp_rec_q   <= '0;
              st_q        <= ST_IDLE;
            end else begin
              pte_q     <= pte_marked;
              pte_raw_q <= mem_rdata;
              if (tbl_clean) begin
                rsp_valid_q <= 1'b1;
                rsp_fault_q <= fin_fault;
                rsp_code_q  <= fault_code(walk_rec, fin_fault);
                rsp_rec_q   <= walk_rec;
                st_q        <= ST_IDLE;
              end else begin
                st_q <= ST_TBL_WB;
              end
            end
          end
        end
        ST_TBL_WB: begin
          if (fire) begin
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= fin_fault;
            rsp_code_q  <= fault_code(walk_rec, fin_fault);
            rsp_rec_q   <= walk_rec;
            st_q        <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_rec   = rsp_rec_q;

  // R10: a waiting memory transaction holds its address, kind and data
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

  // R11: a finished walk answers on the next cycle and goes back to idle
  p_walk_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> rsp_valid && req_ready);

  // R4: a table write-back differs from what was read and carries the status bits
  p_tbl_wb_changes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wb_fire |-> (mem_wdata != pte_raw_q) && mem_wdata[BIT_A]
                    && (!wr_q || mem_wdata[BIT_D]));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int TLB_ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [19:0] dir_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [19:0] req_page,
  input  logic        req_write,
  input  logic [1:0]  req_cpl,
  input  logic        req_wp,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [2:0]  rsp_code,
  output logic [19:0] rsp_frame,
  output logic        rsp_writable,
  output logic        rsp_user
);

  logic               lk_hit, fill_en, hit_serve;
  xlate_t             lk_rec, fill_rec, rsp_rec;
  logic [FRAME_W-1:0] fill_vpn;

  ptw_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_vpn   (req_page),
    .lk_hit   (lk_hit),
    .lk_rec   (lk_rec),
    .fill_en  (fill_en),
    .fill_vpn (fill_vpn),
    .fill_rec (fill_rec)
  );

  ptw_walk u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vpn   (req_page),
    .req_write (req_write),
    .req_cpl   (req_cpl),
    .req_wp    (req_wp),
    .dir_base  (dir_base),
    .lk_hit    (lk_hit),
    .lk_rec    (lk_rec),
    .fill_en   (fill_en),
    .fill_vpn  (fill_vpn),
    .fill_rec  (fill_rec),
    .hit_serve (hit_serve),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_code  (rsp_code),
    .rsp_rec   (rsp_rec)
  );

  assign rsp_frame    = rsp_rec.frame;
  assign rsp_writable = rsp_rec.wr_ok;
  assign rsp_user     = rsp_rec.usr_ok;

  // R7: a cached page answers next cycle without opening a memory transaction
  p_hit_quick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_serve |=> rsp_valid && !mem_valid);

  // R2: a not-present fault reports an all-zero code and frame
  p_absent_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault && !rsp_code[0] |-> (rsp_code == 3'b000) && (rsp_frame == '0)
                                              && !rsp_writable && !rsp_user);

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;

  localparam int N = 16;
  localparam logic [19:0] BASE = 20'h00100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_page = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic        req_wp = 1'b0;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, mem_valid, mem_we, rsp_valid, rsp_fault, rsp_writable, rsp_user;
  logic [31:0] mem_addr, mem_wdata;
  logic [2:0]  rsp_code;
  logic [19:0] rsp_frame;

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dir_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
    .req_write(req_write), .req_cpl(req_cpl), .req_wp(req_wp),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_frame(rsp_frame), .rsp_writable(rsp_writable), .rsp_user(rsp_user)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
  } op_t;

  logic [31:0] mem [logic [31:0]];
  op_t         exp_q[$];
  int          errs = 0;
  int          checks = 0;
  int          cyc = 0;
  bit          stall = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  // model of the translation cache
  bit          m_val [N];
  logic [19:0] m_tag [N];
  logic [19:0] m_frm [N];
  bit          m_w   [N];
  bit          m_u   [N];
  int          m_ptr = 0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory responder and per-cycle transaction comparison
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = stall ? (lfsr[0] | lfsr[1]) : 1'b1;
    mem_rdata = peek(mem_addr);
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected memory transaction", {31'd0, mem_we, mem_addr}, 64'd0);
      end else begin
        op_t o;
        o = exp_q.pop_front();
        // R1, R3, R4: address, kind and write data of each entry access
        chk((o.we == mem_we) && (o.addr == mem_addr) && (!o.we || (o.data == mem_wdata)),
            "R1,R3,R4", "memory transaction", {mem_we, mem_addr, mem_wdata[30:0]},
            {o.we, o.addr, o.data[30:0]});
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic push_op(input bit we, input logic [31:0] a, input logic [31:0] d);
    op_t o;
    o.we = we; o.addr = a; o.data = d;
    exp_q.push_back(o);
  endtask

  task automatic flush_all();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
  endtask

  task automatic run(input logic [31:0] lin, input bit wr, input logic [1:0] cpl,
                     input bit wp, input string req);
    logic [19:0] pg;
    logic [31:0] pa, pta, pde, pte, npte;
    int          slot, nops, k;
    bit          ef, ew, eu, present;
    logic [19:0] efr;
    logic [2:0]  ec;
    pg = lin[31:12];
    slot = -1; nops = 0; present = 1'b0;
    ef = 1'b0; ew = 1'b0; eu = 1'b0; efr = '0;
    for (int i = 0; i < N; i++) if (m_val[i] && (m_tag[i] == pg)) slot = i;
    if (slot >= 0) begin
      present = 1'b1; efr = m_frm[slot]; ew = m_w[slot]; eu = m_u[slot];
    end else begin
      pa = ({12'h0, BASE} << 12) + ({22'h0, pg[19:10]} * 4);
      pde = peek(pa);
      push_op(1'b0, pa, 32'h0); nops++;
      if (pde[0]) begin
        if (!pde[5]) begin push_op(1'b1, pa, pde | 32'h20); nops++; end
        pta = (pde & 32'hFFFF_F000) + ({22'h0, pg[9:0]} * 4);
        pte = peek(pta);
        push_op(1'b0, pta, 32'h0); nops++;
        if (pte[0]) begin
          npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (npte != pte) begin push_op(1'b1, pta, npte); nops++; end
          present = 1'b1;
          efr = pte[31:12]; ew = pte[1] & pde[1]; eu = pte[2] & pde[2];
          m_val[m_ptr] = 1'b1; m_tag[m_ptr] = pg; m_frm[m_ptr] = efr;
          m_w[m_ptr] = ew; m_u[m_ptr] = eu;
          m_ptr = (m_ptr + 1) % N;
        end
      end
    end
    if (!present) begin ef = 1'b1; ec = 3'b000; end
    else begin
      ef = (!eu && (cpl != 2'd0)) || (wr && wp && !ew);
      ec = ef ? {eu, ew, 1'b1} : 3'b000;
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready while idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_page = pg; req_write = wr; req_cpl = cpl; req_wp = wp;
    @(posedge clk);
    k = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid) break;
      k++;
      if (k > 500) begin
        chk(1'b0, req, "response timeout", k, nops);
        break;
      end
    end
    chk({rsp_fault, rsp_code, rsp_frame, rsp_writable, rsp_user} == {ef, ec, efr, ew, eu},
        req, "response fault/code/frame/w/u",
        {38'd0, rsp_fault, rsp_code, rsp_frame, rsp_writable, rsp_user},
        {38'd0, ef, ec, efr, ew, eu});
    if (!stall) begin
      // R11 for walks, R7 for hits (nops == 0)
      chk(k == nops, (nops == 0) ? "R7" : "R11", "edges from accept to response", k, nops);
    end
    chk(exp_q.size() == 0, req, "memory transactions outstanding", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    // directory at frame 0x00100; table frames 0x00200..0x00600
    mem[32'h0010_0004] = 32'h0020_0007;           // P W U, accessed clear
    mem[32'h0020_000C] = 32'h1234_5027;           // P W U A
    mem[32'h0020_0014] = 32'hABCD_E027;           // P W U A, dirty clear
    mem[32'h0010_000C] = 32'h0030_0023;           // P W A, user clear
    mem[32'h0030_0004] = 32'h5555_5067;
    mem[32'h0010_0010] = 32'h0040_0027;
    mem[32'h0040_0008] = 32'h6666_6025;           // P U A, not writable
    mem[32'h0010_0014] = 32'h0050_0025;           // directory not writable
    mem[32'h0050_0000] = 32'h7777_7027;
    mem[32'h0010_0018] = 32'h0060_0027;
    for (int i = 0; i < 17; i++) mem[32'h0060_0000 + i * 4] = ((32'h80000 + i) << 12) | 32'h27;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk({req_ready, mem_valid, rsp_valid} == 3'b100, "R12", "idle outputs after reset",
        {61'd0, req_ready, mem_valid, rsp_valid}, 64'd4);

    run(32'h0040_3ABC, 1'b0, 2'd3, 1'b0, "R3");   // directory write-back, then table read
    run(32'h0040_3ABC, 1'b1, 2'd3, 1'b1, "R7");   // hit, no memory traffic even on write
    run(32'h0040_5000, 1'b1, 2'd3, 1'b1, "R4");   // dirty bit set and written back
    run(32'h0040_5000, 1'b0, 2'd0, 1'b0, "R7");
    run(32'h0080_0000, 1'b0, 2'd0, 1'b0, "R2");   // directory entry absent
    run(32'h0040_7000, 1'b1, 2'd0, 1'b0, "R2");   // table entry absent
    run(32'h0040_7000, 1'b0, 2'd0, 1'b0, "R2");   // not cached: walks again
    run(32'h00C0_1000, 1'b0, 2'd3, 1'b0, "R6");   // user fault, code 3
    run(32'h00C0_1000, 1'b0, 2'd0, 1'b0, "R6");   // same page, supervisor: no fault
    run(32'h0100_2000, 1'b1, 2'd3, 1'b1, "R6");   // write-protect fault, code 5
    run(32'h0100_2000, 1'b1, 2'd3, 1'b0, "R8");   // cached despite fault, no fault now
    run(32'h0140_0000, 1'b0, 2'd3, 1'b0, "R5");   // writable ANDed to 0
    run(32'h0140_0000, 1'b1, 2'd3, 1'b1, "R5");
    flush_all();
    run(32'h0040_3ABC, 1'b0, 2'd3, 1'b0, "R9");   // walks again after flush
    flush_all();
    for (int i = 0; i < 17; i++) run(32'h0180_0000 + i * 32'h1000, 1'b0, 2'd3, 1'b0, "R8");
    run(32'h0180_0000, 1'b0, 2'd3, 1'b0, "R8");   // evicted by the 17th fill
    run(32'h0181_0000, 1'b0, 2'd3, 1'b0, "R8");   // still cached

    stall = 1'b1;
    flush_all();
    run(32'h0040_5000, 1'b0, 2'd3, 1'b0, "R10");
    run(32'h0180_1000, 1'b1, 2'd3, 1'b1, "R4");
    run(32'h0100_2000, 1'b1, 2'd3, 1'b1, "R6");
    run(32'h0080_0000, 1'b0, 2'd0, 1'b0, "R2");
    run(32'h0040_5000, 1'b1, 2'd0, 1'b0, "R7");
    stall = 1'b0;

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule